// File: doc/BRIEF.md
# Programmable Logic Pin-Probe Walker

This block characterises an unknown combinational programmable-logic device from the outside. It needs no knowledge of which pins are inputs and which are outputs. Each of the lowest N candidate pins gets its own tri-state driver, and every one of them starts out as an input. The walker then counts through every binary combination of those N pins. For each combination it applies the vector and waits a programmable settle time. It then reads every pin back. A pin whose sensed level disagrees with the value being driven is being driven by the device itself. For that combination the pin is flagged as an output, and its sensed level is recorded in place of the driven one.

Each step produces one record on the result port. The record holds the applied vector, the sensed level of every pin and the output flags. Together these give a truth table and the data needed to rebuild each pin's output-enable term. A pin can be read three ways from a record:

- a cleared flag means the pin followed the drive, so it is high-impedance and acts as an input;
- a set flag with the sensed bit at 1 means the device drives the pin high;
- a set flag with the sensed bit at 0 means the device drives the pin low.

The controller is a four-state machine:

- IDLE goes to SETTLE on an accepted start.
- SETTLE goes to SAMPLE when the settle timer expires.
- SAMPLE goes back to SETTLE when more vectors remain, or to FINISH after the last vector.
- FINISH always goes to IDLE.

Reset from any state returns the machine to IDLE.

Top module: `pin_probe_walker`

## Requirements
- R1: After reset, `pin_oe`, `pin_drive`, `rec_valid` and `done` are all zero.
- R2: `start` is accepted only in IDLE and only when `pin_count` is in 1..16. A start outside that range is ignored: no pin is enabled and no record is produced.
- R3: In SETTLE and SAMPLE, `pin_oe[i]` is 1 exactly for i < N, and `pin_drive[i]` equals bit i of the current vector for those pins. All other pins are zero. In IDLE and FINISH, both buses are zero.
- R4: The vectors go up in binary from 0 to 2^N-1, where bit i of the vector is pin i. Exactly one record is written per vector.
- R5: With settle value S, where 0 is treated as 1, `rec_valid` for step k is high in the cycle that begins (k+1)(S+1) clock edges after the edge that accepted start.
- R6: `rec_sensed` holds the level of every pin as sampled in the SAMPLE cycle of that step, including pins at or above N.
- R7: `rec_is_out[i]` is 1 exactly when i < N and the sensed level of pin i differs from the driven bit.
- R8: `done` is high for exactly one cycle, one cycle after the final record's `rec_valid`.
- R9: `pin_count` and `settle_cycles` are latched when start is accepted. Changing them during a walk has no effect.
- R10: Asserting reset during a walk tri-states every pin at once. No further record follows.
- R11: A start held high in the cycle where `done` is high begins a new walk on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted in IDLE) |
| pin_count | input | 5 | Number N of probed pins, 1..16 |
| settle_cycles | input | 8 | Settle delay in cycles, 0 treated as 1 |
| pin_sense | input | 16 | Sensed level of each pin |
| pin_drive | output | 16 | Value offered to each pin's driver |
| pin_oe | output | 16 | Driver enable per pin |
| rec_valid | output | 1 | Record strobe, one cycle per step |
| rec_vector | output | 16 | Vector applied for this record |
| rec_sensed | output | 16 | Sensed pin levels for this record |
| rec_is_out | output | 16 | Pins found driven by the device |
| done | output | 1 | One-cycle pulse after the last record |

## Verification
Two events can fall in the same cycle: the completion pulse of one walk and the acceptance of the next start. The bench waits until `done` is seen high, then raises `start` with a new pin count and settle value before the next edge. The bench's cycle-by-cycle model expects two things: the FINISH-to-IDLE pulse still lasts exactly one cycle, and the new walk's drivers turn on right after that edge, followed by its first record at the settle-derived cycle. A second collision, reset arriving mid-walk, is judged by checking that every driver is off at once and that no record strobe follows.

// File: rtl/probe_pkg.sv
package probe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_SAMPLE = 2'd2,
        ST_FINISH = 2'd3
    } walk_state_t;

endpackage

// File: rtl/probe_vec_counter.sv
module probe_vec_counter #(
    parameter int P = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [P-1:0] span_mask,
    output logic [P-1:0] vec,
    output logic         last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec <= '0;
        end else if (clear) begin
            vec <= '0;
        end else if (step) begin
            vec <= vec + P'(1);
        end
    end

    // The final vector has every probed bit set.
    assign last = (vec == span_mask);

    // R4
    vec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> (vec == $past(vec) + P'(1)));

endmodule

// File: rtl/probe_settle_timer.sv
module probe_settle_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] value,
    output logic             expired
);

    logic [DLY_W-1:0] remain_q;
    logic [DLY_W-1:0] eff_value;

    // A zero setting is stretched to the shortest legal delay.
    assign eff_value = (value == '0) ? DLY_W'(1) : value;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= eff_value;
        end else if (remain_q > DLY_W'(1)) begin
            remain_q <= remain_q - DLY_W'(1);
        end
    end

    assign expired = (remain_q == DLY_W'(1));

    // R5
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (remain_q != '0));

endmodule

// File: rtl/probe_pin_io.sv
module probe_pin_io #(
    parameter int P = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         drive_en,
    input  logic         capture,
    input  logic [P-1:0] span_mask,
    input  logic [P-1:0] vec,
    input  logic [P-1:0] pin_sense,
    output logic [P-1:0] pin_drive,
    output logic [P-1:0] pin_oe,
    output logic         rec_valid,
    output logic [P-1:0] rec_vector,
    output logic [P-1:0] rec_sensed,
    output logic [P-1:0] rec_is_out
);

    logic [P-1:0] clash;

    for (genvar i = 0; i < P; i++) begin : g_pin
        assign pin_oe[i]    = drive_en & span_mask[i];
        assign pin_drive[i] = drive_en & span_mask[i] & vec[i];
        // A probed pin that reads back differently is held by the device.
        assign clash[i]     = span_mask[i] & (pin_sense[i] ^ vec[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_valid  <= 1'b0;
            rec_vector <= '0;
            rec_sensed <= '0;
            rec_is_out <= '0;
        end else begin
            rec_valid <= capture;
            if (capture) begin
                rec_vector <= vec;
                rec_sensed <= pin_sense;
                rec_is_out <= clash;
            end
        end
    end

    // R7
    flag_needs_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> ((rec_is_out & ~(rec_sensed ^ rec_vector)) == '0));

    // R6
    record_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !$past(capture)) |-> 1'b0);

endmodule

// File: rtl/pin_probe_walker.sv
module pin_probe_walker
    import probe_pkg::*;
#(
    parameter  int P     = 16,
    parameter  int DLY_W = 8,
    localparam int CNT_W = $clog2(P + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] pin_count,
    input  logic [DLY_W-1:0] settle_cycles,
    input  logic [P-1:0]     pin_sense,
    output logic [P-1:0]     pin_drive,
    output logic [P-1:0]     pin_oe,
    output logic             rec_valid,
    output logic [P-1:0]     rec_vector,
    output logic [P-1:0]     rec_sensed,
    output logic [P-1:0]     rec_is_out,
    output logic             done
);

    walk_state_t      state_q, state_d;
    logic [P-1:0]     span_q;
    logic [P-1:0]     span_new;
    logic [DLY_W-1:0] settle_q;
    logic [DLY_W-1:0] tmr_value;
    logic [P-1:0]     vec;
    logic             vec_last;
    logic             tmr_expired;
    logic             start_ok;
    logic             cnt_clear;
    logic             cnt_step;
    logic             tmr_load;
    logic             drive_en;
    logic             capture;

    for (genvar i = 0; i < P; i++) begin : g_span
        assign span_new[i] = (CNT_W'(i) < pin_count);
    end

    assign start_ok = start && (pin_count != '0) && (pin_count <= CNT_W'(P));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_ok)    state_d = ST_SETTLE;
            ST_SETTLE: if (tmr_expired) state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = vec_last ? ST_FINISH : ST_SETTLE;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs and walk configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            span_q   <= '0;
            settle_q <= '0;
        end else begin
            done <= (state_q == ST_FINISH);
            if (cnt_clear) begin
                span_q   <= span_new;
                settle_q <= settle_cycles;
            end
        end
    end

    assign cnt_clear = (state_q == ST_IDLE) && start_ok;
    assign cnt_step  = (state_q == ST_SAMPLE) && !vec_last;
    assign tmr_load  = cnt_clear || cnt_step;
    assign tmr_value = (state_q == ST_IDLE) ? settle_cycles : settle_q;
    assign drive_en  = (state_q == ST_SETTLE) || (state_q == ST_SAMPLE);
    assign capture   = (state_q == ST_SAMPLE);

    probe_vec_counter #(.P(P)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cnt_clear),
        .step      (cnt_step),
        .span_mask (span_q),
        .vec       (vec),
        .last      (vec_last)
    );

    probe_settle_timer #(.DLY_W(DLY_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .value   (tmr_value),
        .expired (tmr_expired)
    );

    probe_pin_io #(.P(P)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .drive_en   (drive_en),
        .capture    (capture),
        .span_mask  (span_q),
        .vec        (vec),
        .pin_sense  (pin_sense),
        .pin_drive  (pin_drive),
        .pin_oe     (pin_oe),
        .rec_valid  (rec_valid),
        .rec_vector (rec_vector),
        .rec_sensed (rec_sensed),
        .rec_is_out (rec_is_out)
    );

    // R8
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    idle_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_FINISH) |-> (pin_oe == '0));

    // R3
    walk_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE || state_q == ST_SAMPLE) |-> (pin_oe == span_q));

    // R5
    sample_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE) |-> ($past(state_q) == ST_SETTLE));

    // R4
    record_follows_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE) |=> rec_valid);

endmodule

// File: tb/tb_pin_probe_walker.sv
`timescale 1ns/1ps
module tb_pin_probe_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  pin_count = 5'd0;
    logic [7:0]  settle_cycles = 8'd0;
    logic [15:0] pin_sense;
    logic [15:0] pin_drive, pin_oe, rec_vector, rec_sensed, rec_is_out;
    logic        rec_valid, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rec_cnt = 0;

    always #2.5 clk = ~clk;

    pin_probe_walker dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pin_count(pin_count),
        .settle_cycles(settle_cycles), .pin_sense(pin_sense),
        .pin_drive(pin_drive), .pin_oe(pin_oe), .rec_valid(rec_valid),
        .rec_vector(rec_vector), .rec_sensed(rec_sensed),
        .rec_is_out(rec_is_out), .done(done)
    );

    // Emulated device: pin3 = p0&p1 always driven, pin4 = p0^p2 driven when p1,
    // pin9 = ~p5 always driven; every other pin floats and reads as pulled low.
    function automatic logic [15:0] dev_resolve(input logic [15:0] drv, input logic [15:0] oe);
        logic [15:0] s;
        logic [15:0] in;
        in = drv & oe;
        s = in;
        s[3] = in[0] & in[1];
        if (in[1]) s[4] = in[0] ^ in[2];
        s[9] = ~in[5];
        return s;
    endfunction

    always_comb pin_sense = dev_resolve(pin_drive, pin_oe);

    function automatic logic [15:0] span_of(input int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    // Behavioural reference model
    bit          m_active, m_finish, exp_valid, exp_done;
    int          m_n, m_s, m_cnt, m_vec;
    logic [15:0] e_vec, e_sensed, e_isout;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_active = 0; m_finish = 0; exp_valid = 0; exp_done = 0;
            m_n = 0; m_s = 0; m_cnt = 0; m_vec = 0;
        end else begin
            exp_valid = 0;
            exp_done = 0;
            if (m_finish) begin
                exp_done = 1;
                m_finish = 0;
            end else if (!m_active) begin
                if (start && pin_count >= 1 && pin_count <= 16) begin
                    m_active = 1;
                    m_n = pin_count;
                    m_s = (settle_cycles == 0) ? 1 : settle_cycles;
                    m_vec = 0;
                    m_cnt = m_s + 1;
                end
            end else begin
                m_cnt--;
                if (m_cnt == 0) begin
                    exp_valid = 1;
                    e_vec = 16'(m_vec);
                    e_sensed = dev_resolve(16'(m_vec), span_of(m_n));
                    e_isout = (e_sensed ^ 16'(m_vec)) & span_of(m_n);
                    if (m_vec == (1 << m_n) - 1) begin
                        m_active = 0;
                        m_finish = 1;
                    end else begin
                        m_vec++;
                        m_cnt = m_s + 1;
                    end
                end
            end
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (rec_valid) rec_cnt++;
        check("R3 oe", pin_oe, m_active ? span_of(m_n) : 16'h0);
        check("R3 drive", pin_drive, m_active ? (16'(m_vec) & span_of(m_n)) : 16'h0);
        check("R5 rec_valid", {15'h0, rec_valid}, {15'h0, exp_valid});
        check("R8 done", {15'h0, done}, {15'h0, exp_done});
        if (rec_valid && exp_valid) begin
            check("R4 vector", rec_vector, e_vec);
            check("R6 sensed", rec_sensed, e_sensed);
            check("R7 is_out", rec_is_out, e_isout);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic launch(input logic [4:0] n, input logic [7:0] s);
        pin_count = n; settle_cycles = s; start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (done !== 1'b1 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        tick(1);
    endtask

    initial begin
        tick(3);
        @(negedge clk);
        check("R1 oe", pin_oe, 16'h0);
        check("R1 drive", pin_drive, 16'h0);
        check("R1 valid", {15'h0, rec_valid}, 16'h0);
        check("R1 done", {15'h0, done}, 16'h0);
        tick(1);
        rst_n = 1'b1;
        tick(2);

        // R2: out-of-range counts are ignored
        rec_cnt = 0;
        launch(5'd0, 8'd1);
        tick(5);
        launch(5'd17, 8'd1);
        tick(5);
        check("R2 no walk oe", pin_oe, 16'h0);
        check("R2 no records", 16'(rec_cnt), 16'h0);

        // R4/R5: three pins, settle 2
        rec_cnt = 0;
        launch(5'd3, 8'd2);
        wait_done();
        check("R4 record count n3", 16'(rec_cnt), 16'd8);

        // R9: inputs changed mid-walk, settle 0 behaves as 1
        rec_cnt = 0;
        launch(5'd5, 8'd0);
        tick(4);
        pin_count = 5'd2; settle_cycles = 8'd9;
        wait_done();
        check("R9 record count unaffected", 16'(rec_cnt), 16'd32);

        // R11: start held in the done cycle
        rec_cnt = 0;
        launch(5'd8, 8'd1);
        while (done !== 1'b1) @(negedge clk);
        check("R11 done seen", {15'h0, done}, 16'h1);
        pin_count = 5'd2; settle_cycles = 8'd3; start = 1'b1;
        tick(1);
        start = 1'b0;
        @(negedge clk);
        check("R11 new walk enables", pin_oe, 16'h0003);
        wait_done();
        check("R11 records both walks", 16'(rec_cnt), 16'd260);

        // R7/R6: ten pins so the always-driven pin 9 is probed
        rec_cnt = 0;
        launch(5'd10, 8'd1);
        wait_done();
        check("R7 record count n10", 16'(rec_cnt), 16'd1024);

        // R10: reset mid-walk
        launch(5'd4, 8'd4);
        tick(20);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 drivers off", pin_oe, 16'h0);
        tick(1);
        rst_n = 1'b1;
        rec_cnt = 0;
        tick(30);
        check("R10 no further records", 16'(rec_cnt), 16'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(150000 * 5);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule